// File: doc/BRIEF.md
# Weighted Virtual Channel Arbiter

This block decides which of three virtual channels may send its next packet on a shared output port. The three channels are posted requests, nonposted requests and responses. Each channel holds its request line high while it has a packet ready. When no grant is outstanding, the arbiter grants one requesting channel. It keeps that grant until a packet-done strobe arrives, and makes its next choice one cycle later.

The nonposted and response channels have unit weight and share the port in strict rotation. The posted channel is weighted by 2^-PW, where PW is a 2-bit configuration input. While other channels compete, the posted channel is skipped until it has been passed over 2^PW - 1 times. With PW = 3, which is the value software is expected to load after reset, posted traffic gets one slot for every eight slots given to the others. With PW = 0 the posted channel joins the plain rotation. The arbiter never idles the port while any channel has work, so a posted request that is the only request is granted at once.

The block only produces grants. It does not hold packet data and it does not track flow-control credits.

Top module: `wvc_arbiter`

## Requirements
- R1: `vc_gnt` is one-hot or all zero. Bit 0 is the posted channel, bit 1 the nonposted channel and bit 2 the response channel, and the same bit order is used on `vc_req`.
- R2: A grant is made on the clock edge that samples `vc_gnt` at zero and `vc_req` non-zero. It goes only to a channel whose request bit was set at that edge.
- R3: While a grant is held and `pkt_done` is low, `vc_gnt` stays unchanged whatever `vc_req` and `post_wt` do.
- R4: An edge that samples `pkt_done` high with a grant held clears `vc_gnt`. The next grant appears one edge later. `pkt_done` has no effect while `vc_gnt` is zero.
- R5: Rotation: after channel k is granted, the order of priority for eligible channels is k+1, k+2 and then k, modulo 3. After reset the order starts at the posted channel.
- R6: When the nonposted or response channel is also requesting, the posted channel is eligible only once its skip count reaches 2^PW - 1. A decision that grants another channel while posted is requesting adds one to the count, up to a maximum of 7. A posted grant clears the count.
- R7: With `post_wt` = 0, the posted channel competes in the rotation exactly like the other two channels.
- R8: Work conservation: a posted request that is the only request is granted whatever the skip count holds. With no request, `vc_gnt` stays zero.
- R9: A new `post_wt` value is applied at the very next decision, using the skip count already accumulated.
- R10: Reset (`rst_n` low) clears the grant and the skip count, and points the rotation at the posted channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| vc_req | input | 3 | Request per channel: bit 0 posted, bit 1 nonposted, bit 2 response |
| pkt_done | input | 1 | The packet of the granted channel has finished |
| post_wt | input | 2 | PW: the posted channel weight is 2^-PW |
| vc_gnt | output | 3 | One-hot grant, same bit order as vc_req |

## Verification
With all three channels requesting under PW = 3, the grant stream must show eight alternating nonposted and response grants before a single posted grant. This separates a correct skip threshold, and a correct saturating count, from off-by-one variants. The same full load under PW = 0 must give a plain three-way rotation. A posted request paired with only a response tests PW = 1 while the nonposted channel is silent, and posted paired with only a nonposted request tests PW = 2 while the response channel is silent. These runs check that the count grows only when posted actually loses. A posted request on its own must be granted at once (work conservation). A load without posted traffic checks that the pointer skips an idle channel. Changing PW in the middle of a pass checks that the new threshold acts on the next decision. Directed steps cover holding a grant while the requests change, a done strobe sent while idle, and the priority order right after a release.

// File: rtl/wvc_arb_pkg.sv
package wvc_arb_pkg;

  localparam int NUM_VC = 3;

  typedef enum logic [1:0] {
    VC_POSTED    = 2'd0,
    VC_NONPOSTED = 2'd1,
    VC_RESPONSE  = 2'd2
  } vc_e;

  // Number of pass-overs the posted channel needs before it may win
  function automatic int skip_limit(int pw);
    return (1 << pw) - 1;
  endfunction

  // Index following idx in circular order
  function automatic int next_vc(int idx);
    return (idx == NUM_VC - 1) ? 0 : idx + 1;
  endfunction

endpackage

// File: rtl/wvc_skip_ctr.sv
module wvc_skip_ctr
  import wvc_arb_pkg::*;
#(
  parameter int PW_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PW_W-1:0]   pw,
  input  logic              post_req,
  input  logic              rival_req,
  input  logic              post_win,
  input  logic              post_passed,
  output logic              post_elig,
  output logic [(2**PW_W)-2:0] skip_cnt
);
  localparam int CNT_W = (2**PW_W) - 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;
  logic             limit_met;

  always_comb begin
    limit     = CNT_W'(skip_limit(int'(pw)));
    limit_met = (cnt_q >= limit);
    post_elig = post_req && (!rival_req || limit_met);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (post_win)
      cnt_q <= '0;
    else if (post_passed && (cnt_q != CNT_MAX))
      cnt_q <= cnt_q + CNT_W'(1);
  end

  assign skip_cnt = cnt_q;

  // R6: a posted win leaves the count at zero
  a_r6_clear_on_win: assert property (@(posedge clk) disable iff (!rst_n)
    post_win |=> (skip_cnt == '0));

  // R6: a pass-over below saturation raises the count by exactly one
  a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (post_passed && !post_win && skip_cnt != CNT_MAX) |=>
      (skip_cnt == $past(skip_cnt) + CNT_W'(1)));

endmodule

// File: rtl/wvc_rotator.sv
module wvc_rotator
  import wvc_arb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_VC-1:0] elig,
  input  logic              take,
  output logic [NUM_VC-1:0] pick
);
  logic [1:0] ptr_q;
  logic [1:0] ptr_nxt;

  always_comb begin
    pick = '0;
    for (int k = 0; k < NUM_VC; k++) begin
      int idx;
      idx = int'(ptr_q) + k;
      if (idx >= NUM_VC) idx = idx - NUM_VC;
      if ((pick == '0) && elig[idx]) pick[idx] = 1'b1;
    end
  end

  always_comb begin
    ptr_nxt = ptr_q;
    for (int i = 0; i < NUM_VC; i++)
      if (pick[i]) ptr_nxt = 2'(next_vc(i));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      ptr_q <= 2'(VC_POSTED);
    else if (take && (pick != '0))
      ptr_q <= ptr_nxt;
  end

  // R2: the rotator never picks a channel that is not eligible
  a_r2_pick_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    (pick & ~elig) == '0);

  // R5: the pointer always lands on a valid channel index
  a_r5_ptr_range: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q < 2'(NUM_VC));

endmodule

// File: rtl/wvc_arbiter.sv
module wvc_arbiter
  import wvc_arb_pkg::*;
#(
  parameter int PW_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        vc_req,
  input  logic              pkt_done,
  input  logic [PW_W-1:0]   post_wt,
  output logic [2:0]        vc_gnt
);
  localparam int CNT_W = (2**PW_W) - 1;

  logic [NUM_VC-1:0] gnt_q;
  logic [NUM_VC-1:0] elig;
  logic [NUM_VC-1:0] pick;
  logic              decide;
  logic              release_ev;
  logic              post_elig;
  logic              post_win;
  logic              post_passed;
  logic              rival_req;
  logic [CNT_W-1:0]  skip_cnt;

  // Named events for the assertions
  assign decide      = (gnt_q == '0) && (vc_req != '0);
  assign release_ev  = (gnt_q != '0) && pkt_done;
  assign rival_req   = vc_req[VC_NONPOSTED] || vc_req[VC_RESPONSE];
  assign post_win    = decide && pick[VC_POSTED];
  assign post_passed = decide && vc_req[VC_POSTED] && !pick[VC_POSTED];

  assign elig = {vc_req[VC_RESPONSE], vc_req[VC_NONPOSTED], post_elig};

  wvc_skip_ctr #(.PW_W(PW_W)) u_skip (
    .clk         (clk),
    .rst_n       (rst_n),
    .pw          (post_wt),
    .post_req    (vc_req[VC_POSTED]),
    .rival_req   (rival_req),
    .post_win    (post_win),
    .post_passed (post_passed),
    .post_elig   (post_elig),
    .skip_cnt    (skip_cnt)
  );

  wvc_rotator u_rot (
    .clk   (clk),
    .rst_n (rst_n),
    .elig  (elig),
    .take  (decide),
    .pick  (pick)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)
      gnt_q <= '0;
    else if (release_ev)
      gnt_q <= '0;
    else if (decide)
      gnt_q <= pick;
  end

  assign vc_gnt = gnt_q;

  a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(vc_gnt));

  a_r2_to_requester: assert property (@(posedge clk) disable iff (!rst_n)
    decide |=> ((vc_gnt & $past(vc_req)) != '0));

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((vc_gnt != '0) && !pkt_done) |=> $stable(vc_gnt));

  a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
    ((vc_gnt != '0) && pkt_done) |=> (vc_gnt == '0));

  a_r8_no_req_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ((vc_gnt == '0) && (vc_req == '0)) |=> (vc_gnt == '0));

  a_r6_posted_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (post_win && rival_req) |->
      (int'(skip_cnt) >= skip_limit(int'(post_wt))));

endmodule

// File: tb/test_wvc_arbiter.sv
`timescale 1ns/1ps
module test_wvc_arbiter;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] vc_req = '0;
  logic       pkt_done = 1'b0;
  logic [1:0] post_wt = 2'd3;
  logic [2:0] vc_gnt;

  int n_checks = 0;
  int n_fails  = 0;

  always #4 clk = ~clk;

  wvc_arbiter i_wvc_arbiter (
    .clk      (clk),
    .rst_n    (rst_n),
    .vc_req   (vc_req),
    .pkt_done (pkt_done),
    .post_wt  (post_wt),
    .vc_gnt   (vc_gnt)
  );

  // {req[2:0], pw[1:0], expected grant[2:0]}, walked after a reset
  localparam logic [7:0] VEC [0:30] = '{
    8'b111_11_010, 8'b111_11_100, 8'b111_11_010, 8'b111_11_100,
    8'b111_11_010, 8'b111_11_100, 8'b111_11_010, 8'b111_11_100,
    8'b111_11_001,
    8'b111_00_010, 8'b111_00_100, 8'b111_00_001,
    8'b111_00_010, 8'b111_00_100, 8'b111_00_001,
    8'b101_01_100, 8'b101_01_001, 8'b101_01_100, 8'b101_01_001,
    8'b001_10_001, 8'b001_10_001,
    8'b110_10_010, 8'b110_10_100, 8'b110_10_010,
    8'b011_10_010, 8'b011_10_010, 8'b011_10_010, 8'b011_10_001,
    8'b111_11_010, 8'b111_11_100, 8'b111_01_001
  };

  function automatic string vec_tag(int i);
    if (i < 9)  return "R6";
    if (i < 15) return "R7";
    if (i < 19) return "R6";
    if (i < 21) return "R8";
    if (i < 24) return "R5";
    if (i < 28) return "R6";
    return "R9";
  endfunction

  task automatic check(string tag, logic [2:0] got, logic [2:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s: vc_gnt=%b expected %b", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; vc_req = '0; pkt_done = 1'b0; post_wt = 2'd3;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    finish_run();
  end

  initial begin
    // Directed tests
    do_reset();
    check("R10 reset clears grant", vc_gnt, 3'b000);
    repeat (3) @(negedge clk);
    check("R8 no request keeps grant low", vc_gnt, 3'b000);
    pkt_done = 1'b1;
    @(negedge clk);
    pkt_done = 1'b0;
    check("R4 done while idle ignored", vc_gnt, 3'b000);
    vc_req = 3'b010;
    @(negedge clk);
    check("R2 grant to sole requester", vc_gnt, 3'b010);
    check("R1 grant one-hot", 3'($countones(vc_gnt)), 3'd1);
    vc_req  = 3'b101;
    post_wt = 2'd0;
    repeat (3) @(negedge clk);
    check("R3 grant held without done", vc_gnt, 3'b010);
    post_wt  = 2'd3;
    pkt_done = 1'b1;
    @(negedge clk);
    pkt_done = 1'b0;
    check("R4 done releases grant", vc_gnt, 3'b000);
    @(negedge clk);
    check("R5 response follows nonposted", vc_gnt, 3'b100);

    // Vector table
    do_reset();
    for (int i = 0; i < 31; i++) begin
      vc_req  = VEC[i][7:5];
      post_wt = VEC[i][4:3];
      @(negedge clk);
      check(vec_tag(i), vc_gnt, VEC[i][2:0]);
      pkt_done = 1'b1;
      @(negedge clk);
      pkt_done = 1'b0;
    end
    check("R4 release after last vector", vc_gnt, 3'b000);
    finish_run();
  end

endmodule